// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Channel

This block is a single 16-bit timer channel that works in one of three modes, chosen by a 2-bit field in its mode byte. In interval mode it counts down on a divided internal clock. When it underflows it reloads itself and raises an interrupt request. In event mode the same down-counter steps on edges of an external pin, or on the underflow pulse of a neighbouring channel in the ring. In measurement mode the counter counts up on the internal clock. On each qualifying pin edge it captures the elapsed count and restarts from zero, which gives either the period of the signal or the length of each high and low phase.

Software reaches the channel through a byte-wide register port. The port has three locations: the mode byte, the low byte of the data register and the high byte of the data register. A separate run input gates all counting. The channel's chain output is meant to feed the chain input of the next channel in the ring.

Top module: `mtimer_unit`

## Requirements
- R1: After reset, the mode byte (location 0) reads 0x00, both data bytes (locations 1 and 2) read 0x00, and irq_req and chain_out are low.
- R2: In interval mode (mode[1:0]=00), with run_en high, the counter decrements once per tick. A tick taken at count 0 reloads the data register value and pulses irq_req and chain_out high for one clock. Underflows therefore recur every reload+1 ticks.
- R3: The clock field mode[7:6] sets the tick rate used in interval and measurement modes: 00 gives a tick every clock, 01 every 8th clock, 10 every 32nd clock, and 11 every 32nd sub_tick pulse. The dividers are held cleared while run_en is low, so the first tick comes on the 8th or 32nd clock (or sub_tick pulse) after run_en rises.
- R4: Location 1 is the low byte and location 2 the high byte of the data register. A write while run_en is low also loads the counter. Reads of locations 1 and 2 return the counter in modes 00, 01 and 11, and the capture register in mode 10.
- R5: While run_en is low the counter holds its value and irq_req stays low.
- R6: In event mode (mode[1:0]=01) with mode[6]=0, the counter steps on edges of ext_pin after a two-flop synchronizer. mode[4]=0 selects rising edges and mode[4]=1 selects falling edges.
- R7: In event mode with mode[6]=1, the counter steps on each clock in which chain_in is high.
- R8: In measurement mode (mode[1:0]=10) with mode[4]=0, every rising edge of ext_pin captures the number of ticks since the previous rising edge, clears the counter and pulses irq_req. chain_out stays low in this mode.
- R9: In measurement mode with mode[4]=1, both rising and falling edges qualify, so the capture holds the length of the last high or low phase in ticks.
- R10: In measurement mode, a tick taken at count 0xFFFF sets a sticky flag that reads as mode bit 5. Software cannot write that bit. Any write to the mode byte clears the flag.
- R11: Mode field 11 is reserved: the counter does not move and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register location: 0 mode, 1 data low, 2 data high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| run_en | input | 1 | Count enable (start flag) |
| sub_tick | input | 1 | One-clock pulse from the slow sub-clock |
| ext_pin | input | 1 | Asynchronous external input |
| chain_in | input | 1 | Underflow pulse from the neighbouring channel |
| irq_req | output | 1 | One-clock interrupt request |
| chain_out | output | 1 | One-clock underflow pulse to the next channel |

## Verification
The assertions assume that chain_in and sub_tick are synchronous one-clock pulses and that software never selects mode 11 while expecting counting. They also assume that data-register writes while running change only the reload value. The stimulus drives every input on the falling clock edge and spaces pin edges several clocks apart, longer than the synchronizer latency. Each mode is entered only from a stopped channel, after the counter has been loaded through the data register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_W = 16;

    typedef enum logic [1:0] {
        MD_TIMER = 2'b00,
        MD_EVENT = 2'b01,
        MD_MEAS  = 2'b10,
        MD_RSVD  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SRC_F1   = 2'b00,
        SRC_F8   = 2'b01,
        SRC_F32  = 2'b10,
        SRC_FSUB = 2'b11
    } tmr_clk_e;

    localparam logic [1:0] LOC_MODE = 2'd0;
    localparam logic [1:0] LOC_LO   = 2'd1;
    localparam logic [1:0] LOC_HI   = 2'd2;

    localparam int BIT_POL   = 4;
    localparam int BIT_OVF   = 5;
    localparam int BIT_CHAIN = 6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int MID_LOG  = 3,
    parameter int SLOW_LOG = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sub_pulse,
    input  logic [1:0] sel,
    output logic       tick
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [SLOW_LOG-1:0] pre;
        logic [SLOW_LOG-1:0] sub;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.pre = '0;
            st_d.sub = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
            if (sub_pulse) st_d.sub = st_q.sub + 1'b1;
        end
        case (tmr_clk_e'(sel))
            SRC_F1:  tick = run;
            SRC_F8:  tick = run && (st_q.pre[MID_LOG-1:0] == '1);
            SRC_F32: tick = run && (st_q.pre == '1);
            default: tick = run && sub_pulse && (st_q.sub == '1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.pre == '0 && st_q.sub == '0)); // R3
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
        fall      = ~st_q.sh[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic         step,
    input  logic         hit,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         irq,
    output logic         uf,
    output logic         ovf
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
        logic         irq;
        logic         uf;
        logic         ovf;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.uf  = 1'b0;
        if (ovf_clr) st_d.ovf = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (run) begin
            case (tmr_mode_e'(mode))
                MD_TIMER, MD_EVENT: begin
                    if (step) begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt = reload;
                            st_d.irq = 1'b1;
                            st_d.uf  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                MD_MEAS: begin
                    if (hit) begin
                        st_d.cap = st_q.cnt + W'(step);
                        st_d.cnt = '0;
                        st_d.irq = 1'b1;
                    end else if (step) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == '1) st_d.ovf = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;
    assign irq = st_q.irq;
    assign uf  = st_q.uf;
    assign ovf = st_q.ovf;

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> ($stable(st_q.cnt) && !st_q.irq)); // R5
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !load) |=> ($stable(st_q.cnt) && !st_q.irq)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf); // R10
    AST_MEAS_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> !st_q.uf); // R8
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       run_en,
    input  logic       sub_tick,
    input  logic       ext_pin,
    input  logic       chain_in,
    output logic       irq_req,
    output logic       chain_out
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [7:0]       mode;
        logic [TMR_W-1:0] reload;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             wr_mode, wr_lo, wr_hi;
    logic             clk_tick, pin_rise, pin_fall;
    logic             step, hit, load;
    logic [TMR_W-1:0] cnt, cap, view;
    logic             ovf;
    tmr_mode_e        md;

    assign wr_mode = bus_wr && (bus_sel == LOC_MODE);
    assign wr_lo   = bus_wr && (bus_sel == LOC_LO);
    assign wr_hi   = bus_wr && (bus_sel == LOC_HI);
    assign md      = tmr_mode_e'(st_q.mode[1:0]);

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.mode          = bus_wdata;
            st_d.mode[BIT_OVF] = 1'b0;
        end
        if (wr_lo) st_d.reload[7:0]  = bus_wdata;
        if (wr_hi) st_d.reload[15:8] = bus_wdata;
        load = (wr_lo || wr_hi) && !run_en;

        case (md)
            MD_TIMER, MD_MEAS: step = clk_tick;
            MD_EVENT: begin
                if (st_q.mode[BIT_CHAIN]) step = chain_in;
                else if (st_q.mode[BIT_POL]) step = pin_fall;
                else step = pin_rise;
            end
            default: step = 1'b0;
        endcase
        hit = (md == MD_MEAS) &&
              (st_q.mode[BIT_POL] ? (pin_rise || pin_fall) : pin_rise);

        view = (md == MD_MEAS) ? cap : cnt;
        case (bus_sel)
            LOC_MODE: bus_rdata = {st_q.mode[7:6], ovf, st_q.mode[4:0]};
            LOC_LO:   bus_rdata = view[7:0];
            LOC_HI:   bus_rdata = view[15:8];
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_prescaler #(.MID_LOG(3), .SLOW_LOG(5)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en), .sub_pulse(sub_tick),
        .sel(st_q.mode[7:6]), .tick(clk_tick)
    );

    tmr_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
    );

    tmr_count_core #(.W(TMR_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run_en), .mode(st_q.mode[1:0]),
        .step(step), .hit(hit), .load(load), .load_val(st_d.reload),
        .reload(st_q.reload), .ovf_clr(wr_mode), .cnt(cnt), .cap(cap),
        .irq(irq_req), .uf(chain_out), .ovf(ovf)
    );

    AST_OVF_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> !st_q.mode[BIT_OVF]); // R10
endmodule

// File: tb/mtimer_unit_tb_top.sv
module mtimer_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       run_en = 1'b0;
    logic       sub_tick = 1'b1;
    logic       ext_pin = 1'b0;
    logic       chain_in = 1'b0;
    logic       irq_req, chain_out;

    int n_chk = 0, n_fail = 0, irq_n = 0, uf_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtimer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
        .sub_tick(sub_tick), .ext_pin(ext_pin), .chain_in(chain_in),
        .irq_req(irq_req), .chain_out(chain_out)
    );

    always @(negedge clk) begin
        if (irq_req) irq_n++;
        if (chain_out) uf_n++;
    end

    // {mode, reload, cycles, expected irqs, expected counter}
    localparam logic [63:0] VEC [6] = '{
        {8'h00, 16'd4,   16'd23,  8'd4,  16'd1},
        {8'h00, 16'd0,   16'd10,  8'd10, 16'd0},
        {8'h40, 16'd2,   16'd50,  8'd2,  16'd2},
        {8'h80, 16'd1,   16'd130, 8'd2,  16'd1},
        {8'hC0, 16'd0,   16'd100, 8'd3,  16'd0},
        {8'h00, 16'd258, 16'd600, 8'd2,  16'd176}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int v);
        bus_sel = sel;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic rd16(output int v);
        int lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = hi * 256 + lo;
    endtask

    task automatic setup(input logic [7:0] m, input logic [15:0] rel);
        run_en = 1'b0;
        @(negedge clk);
        wr(2'd0, m);
        wr(2'd1, rel[7:0]);
        wr(2'd2, rel[15:8]);
        @(posedge clk);
        irq_n = 0; uf_n = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        run_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pin_cycles(input int hi_len, input int lo_len, input int reps);
        for (int k = 0; k < reps; k++) begin
            ext_pin = 1'b1;
            repeat (hi_len) @(negedge clk);
            ext_pin = 1'b0;
            repeat (lo_len) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 mode byte", v, 0);
        rd16(v);     chk("R1 data", v, 0);
        chk("R1 irq", int'(irq_req), 0);
        chk("R1 chain_out", int'(chain_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 interval mode vectors
        for (int i = 0; i < 6; i++) begin
            logic [63:0] e;
            e = VEC[i];
            setup(e[63:56], e[55:40]);
            run_en = 1'b1;
            repeat (int'(e[39:24])) @(negedge clk);
            finish_run();
            chk($sformatf("R2 R3 vec%0d irq count", i), irq_n, int'(e[23:16]));
            chk($sformatf("R2 vec%0d chain count", i), uf_n, int'(e[23:16]));
            rd16(v);
            chk($sformatf("R2 R4 vec%0d counter", i), v, int'(e[15:0]));
        end

        // R5 stopped counter holds
        setup(8'h00, 16'd9);
        repeat (20) @(negedge clk);
        rd16(v);
        chk("R5 frozen counter", v, 9);
        chk("R5 no irq", irq_n, 0);

        // R11 reserved mode does not count
        setup(8'h03, 16'd5);
        run_en = 1'b1;
        repeat (20) @(negedge clk);
        finish_run();
        rd16(v);
        chk("R11 counter", v, 5);
        chk("R11 irq", irq_n, 0);

        // R6 rising edges
        setup(8'h01, 16'd2);
        run_en = 1'b1;
        pin_cycles(3, 3, 3);
        repeat (6) @(negedge clk);
        chk("R6 rising irq", irq_n, 1);
        rd16(v); chk("R6 rising reload", v, 2);
        pin_cycles(3, 3, 2);
        repeat (6) @(negedge clk);
        rd16(v); chk("R6 rising count", v, 0);
        finish_run();

        // R6 falling edges
        setup(8'h11, 16'd1);
        run_en = 1'b1;
        ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        rd16(v); chk("R6 rise ignored in falling mode", v, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        pin_cycles(3, 3, 1);
        repeat (6) @(negedge clk);
        chk("R6 falling irq", irq_n, 1);
        finish_run();

        // R7 chained source
        setup(8'h41, 16'd2);
        run_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chain_in = 1'b1; @(negedge clk);
            chain_in = 1'b0; @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk("R7 chain irq", irq_n, 1);
        chk("R7 chain out", uf_n, 1);
        finish_run();

        // R8 period measurement
        setup(8'h02, 16'd0);
        run_en = 1'b1;
        pin_cycles(7, 13, 5);
        finish_run();
        rd16(v);
        chk("R8 R4 period capture", v, 20);
        chk("R8 irq count", irq_n, 5);
        chk("R8 no chain out", uf_n, 0);

        // R9 width measurement
        setup(8'h12, 16'd0);
        run_en = 1'b1;
        pin_cycles(7, 13, 5);
        finish_run();
        rd16(v);
        chk("R9 width capture", v, 7);
        chk("R9 irq count", irq_n, 10);

        // R10 overflow flag
        setup(8'h02, 16'd0);
        run_en = 1'b1;
        repeat (65530) @(negedge clk);
        rd(2'd0, v); chk("R10 no flag before wrap", v, 8'h02);
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R10 flag after wrap", v, 8'h22);
        wr(2'd0, 8'h22);
        rd(2'd0, v); chk("R10 flag cleared by write", v, 8'h02);
        finish_run();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule